// File: doc/BRIEF.md
# Parallel-Bundle Stochastic Arithmetic Datapath

This block does arithmetic on fractions in [0,1] using a redundant, probabilistic encoding. Each operand is a bundle of N parallel wires, and the share of wires at one is the operand's value. Three binary operands `a`, `b` and `c` are accepted on a valid/ready stream. Every wire of every operand has its own 16-bit LFSR, and each wire compares that LFSR against the operand, which turns the binary value into a bundle. Two fabrics then work on the bundles.

The shuffled-AND fabric pairs every wire of `a` with one wire of `b` through a fixed pseudo-random bijection, which gives a bundle of density a·b. The bundleplexer takes exactly K fixed, scattered wire positions from `a` and the remaining N−K positions from `c`, which gives a bundle of density r·a + (1−r)·c with r = K/N. An output stage counts the ones in both result bundles. It registers the two counts together with the signed recombination 3·sum − 2·product, so a function with a negative coefficient is carried as two non-negative parts. A consumer averages the results over many beats to reach the precision it needs.

Both stream directions use valid/ready handshakes. An input beat is taken on a clock edge where `in_valid` and `in_ready` are both high, and its results appear on the next cycle. An output beat is held stable until `out_ready` is high. While a result is pending and `out_ready` is low, `in_ready` is low. The LFSRs advance only on accepted beats.

Top module: `sbd_datapath`

## Requirements
- R1: Operands are W+1 = 9 bits wide, and a value v encodes the density v/256. When v = 0, every wire of that bundle is zero. When v = 256, every wire is one.
- R2: Product wire i is the AND of `a` wire i and `b` wire π(i), where π is a fixed bijection. If `a` and `b` are both all ones, `prod_cnt` = N = 64. If either is zero, `prod_cnt` = 0.
- R3: The sum bundle takes exactly K = 48 positions from `a` and the other N−K = 16 from `c`. With a = 1 and c = 0, `sum_cnt` = 48. With a = 0 and c = 1, it is 16. With a = c = 1, it is 64.
- R4: `result` is the two's-complement value 3·`sum_cnt` − 2·`prod_cnt` of the same beat.
- R5: Results for a beat accepted at edge t are valid from edge t onward and are visible in the cycle after t. With no accepted beat and no stalled result, `out_valid` falls.
- R6: While `out_valid` is high and `out_ready` is low, `in_ready` is low, no beat is taken, and all outputs hold. A beat offered during the stall is taken on the edge where the stall clears.
- R7: After reset (`rst_n` low, active low), `out_valid` is 0 and `in_ready` is 1, even if a result was pending.
- R8: Averaged over many beats, `prod_cnt` tends to N·a·b and `sum_cnt` tends to N·(r·a + (1−r)·c). The error falls as 1/sqrt(N·beats).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand beat offered |
| in_ready | output | 1 | Operand beat can be taken |
| a_val | input | 9 | Operand a, density a_val/256 |
| b_val | input | 9 | Operand b, density b_val/256 |
| c_val | input | 9 | Operand c, density c_val/256 |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes result beat |
| prod_cnt | output | 7 | Ones in the product bundle |
| sum_cnt | output | 7 | Ones in the scaled-sum bundle |
| result | output | 9 | Signed 3·sum_cnt − 2·prod_cnt |

## Verification
A wrong permutation or wrong plexer mask shows at the ports one cycle after the first beat with saturated operands, because an all-ones or all-zeros input turns each count into an exact number (64, 48, 16 or 0). A generator stuck at a constant or correlated across wires cannot be seen in a single beat. It shows only as a drift of the averaged counts away from N·a·b and N·(r·a+(1−r)·c), after a few thousand beats. A broken stall path shows within one stalled cycle, either as an output that changes or as a second beat that is lost or taken twice.

// File: rtl/sbd_pkg.sv
package sbd_pkg;

  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;

  // Nonzero per-wire seed, hashed from stream id and wire index.
  function automatic logic [LFSR_W-1:0] wire_seed(input int stream, input int idx);
    int unsigned x;
    logic [LFSR_W-1:0] s;
    x = 32'(stream) * 32'd7919 + 32'(idx) * 32'd104729 + 32'd12345;
    for (int k = 0; k < 3; k++) x = x * 32'd1103515245 + 32'd12345;
    s = x[30:15];
    if (s == '0) s = 16'hACE1;
    return s;
  endfunction

  // Affine map mod a power of two: a bijection when mult is odd.
  function automatic int scatter(input int i, input int mult, input int ofs, input int n);
    return (i * mult + ofs) % n;
  endfunction

endpackage

// File: rtl/sbd_bundle_gen.sv
module sbd_bundle_gen #(
  parameter int N = 64,
  parameter int W = 8,
  parameter int STREAM = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic [W:0]   value,
  output logic [N-1:0] bits
);
  import sbd_pkg::*;

  localparam logic [W:0] FULL = (W+1)'(1) << W;

  for (genvar i = 0; i < N; i++) begin : g_wire
    logic [LFSR_W-1:0] st;
    always_ff @(posedge clk) begin
      if (!rst_n)   st <= wire_seed(STREAM, i);
      else if (adv) st <= (st >> 1) ^ (st[0] ? LFSR_TAPS : '0);
    end
    assign bits[i] = {1'b0, st[W-1:0]} < value;
  end

  p_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (value == '0) |-> (bits == '0));
  p_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (value == FULL) |-> (&bits));

endmodule

// File: rtl/sbd_shuffle_and.sv
module sbd_shuffle_and #(
  parameter int N = 64,
  parameter int MULT = 37,
  parameter int OFS = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N-1:0] y
);
  import sbd_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_pair
    localparam int J = scatter(i, MULT, OFS, N);
    assign y[i] = a[i] & b[J];
  end

  p_and_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(y) <= $countones(a)) && ($countones(y) <= $countones(b)));

endmodule

// File: rtl/sbd_bundleplex.sv
module sbd_bundleplex #(
  parameter int N = 64,
  parameter int K = 48,
  parameter int MULT = 21,
  parameter int OFS = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] a,
  input  logic [N-1:0] c,
  output logic [N-1:0] y
);
  import sbd_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_pick
    localparam int RANK = scatter(i, MULT, OFS, N);
    if (RANK < K) begin : g_from_a
      assign y[i] = a[i];
    end else begin : g_from_c
      assign y[i] = c[i];
    end
  end

  p_plex_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (&a) |-> ($countones(y) >= K));
  p_plex_ceil_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (c == '0) |-> ($countones(y) <= K));

endmodule

// File: rtl/sbd_tally.sv
module sbd_tally #(
  parameter int N = 64,
  parameter int POS_W = 3,
  parameter int NEG_W = 2,
  parameter int CW = 7,
  parameter int RW = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [N-1:0]         pos_bits,
  input  logic [N-1:0]         neg_bits,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [CW-1:0]        sum_cnt,
  output logic [CW-1:0]        prod_cnt,
  output logic signed [RW-1:0] result
);
  logic [CW-1:0] pos_c, neg_c;
  logic signed [RW-1:0] res_d;
  logic fire;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_comb begin
    pos_c = '0;
    neg_c = '0;
    for (int i = 0; i < N; i++) begin
      pos_c = pos_c + CW'(pos_bits[i]);
      neg_c = neg_c + CW'(neg_bits[i]);
    end
    res_d = RW'(POS_W * int'(pos_c) - NEG_W * int'(neg_c));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      sum_cnt   <= '0;
      prod_cnt  <= '0;
      result    <= '0;
    end else if (fire) begin
      out_valid <= 1'b1;
      sum_cnt   <= pos_c;
      prod_cnt  <= neg_c;
      result    <= res_d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(sum_cnt) && $stable(prod_cnt) && $stable(result)));
  p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && in_ready) && !(out_valid && !out_ready)) |=> !out_valid);

endmodule

// File: rtl/sbd_datapath.sv
module sbd_datapath #(
  parameter int N = 64,
  parameter int W = 8,
  parameter int K = 48,
  parameter int POS_W = 3,
  parameter int NEG_W = 2,
  localparam int CW = $clog2(N + 1),
  localparam int RW = $clog2((POS_W > NEG_W ? POS_W : NEG_W) * N + 1) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [W:0]           a_val,
  input  logic [W:0]           b_val,
  input  logic [W:0]           c_val,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [CW-1:0]        prod_cnt,
  output logic [CW-1:0]        sum_cnt,
  output logic signed [RW-1:0] result
);
  logic [N-1:0] a_b, b_b, c_b, prod_b, sum_b;
  logic adv;

  assign adv = in_valid && in_ready;

  sbd_bundle_gen #(.N(N), .W(W), .STREAM(1)) u_gen_a (
    .clk(clk), .rst_n(rst_n), .adv(adv), .value(a_val), .bits(a_b));
  sbd_bundle_gen #(.N(N), .W(W), .STREAM(2)) u_gen_b (
    .clk(clk), .rst_n(rst_n), .adv(adv), .value(b_val), .bits(b_b));
  sbd_bundle_gen #(.N(N), .W(W), .STREAM(3)) u_gen_c (
    .clk(clk), .rst_n(rst_n), .adv(adv), .value(c_val), .bits(c_b));

  sbd_shuffle_and #(.N(N)) u_mul (
    .clk(clk), .rst_n(rst_n), .a(a_b), .b(b_b), .y(prod_b));

  sbd_bundleplex #(.N(N), .K(K)) u_add (
    .clk(clk), .rst_n(rst_n), .a(a_b), .c(c_b), .y(sum_b));

  sbd_tally #(.N(N), .POS_W(POS_W), .NEG_W(NEG_W), .CW(CW), .RW(RW)) u_tally (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .pos_bits(sum_b), .neg_bits(prod_b), .out_valid(out_valid),
    .out_ready(out_ready), .sum_cnt(sum_cnt), .prod_cnt(prod_cnt),
    .result(result));

endmodule

// File: tb/sbd_datapath_tb.sv
`timescale 1ns/1ps
module sbd_datapath_tb;
  localparam int N = 64;
  localparam int K = 48;
  localparam int CYC = 2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic [8:0] a_val = '0, b_val = '0, c_val = '0;
  logic in_ready, out_valid;
  logic [6:0] prod_cnt, sum_cnt;
  logic signed [8:0] result;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sbd_datapath u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .a_val(a_val), .b_val(b_val), .c_val(c_val), .out_valid(out_valid),
    .out_ready(out_ready), .prod_cnt(prod_cnt), .sum_cnt(sum_cnt),
    .result(result));

  // a, b, c, prod_cnt, sum_cnt, result for saturated operands
  localparam int TV [6][6] = '{
    '{256, 256, 256, 64, 64,  64},
    '{256,   0,   0,  0, 48, 144},
    '{  0, 256, 256,  0, 16,  48},
    '{  0,   0,   0,  0,  0,   0},
    '{256, 256,   0, 64, 48,  16},
    '{256,   0, 256,  0, 64, 192}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put(input int a, input int b, input int c);
    a_val = 9'(a); b_val = 9'(b); c_val = 9'(c);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic stat_run(input int a, input int b, input int c);
    real sp, ss, ep, es, tol;
    int bad_res;
    sp = 0.0; ss = 0.0; bad_res = 0;
    a_val = 9'(a); b_val = 9'(b); c_val = 9'(c);
    in_valid = 1'b1;
    out_ready = 1'b1;
    for (int k = 0; k < CYC; k++) begin
      @(posedge clk);
      @(negedge clk);
      sp += real'(prod_cnt);
      ss += real'(sum_cnt);
      if (int'(result) != 3 * int'(sum_cnt) - 2 * int'(prod_cnt)) bad_res++;
    end
    in_valid = 1'b0;
    sp /= CYC; ss /= CYC;
    ep = N * (a / 256.0) * (b / 256.0);
    es = N * ((real'(K) / N) * (a / 256.0) + (1.0 - real'(K) / N) * (c / 256.0));
    tol = 20.0 * 0.5 * N / $sqrt(real'(N) * CYC);
    chk(bad_res == 0, "R4 weighted result every beat", bad_res, 0);
    chk((sp - ep < tol) && (ep - sp < tol), "R8 mean product",
        int'(sp * 100.0), int'(ep * 100.0));
    chk((ss - es < tol) && (es - ss < tol), "R8 mean scaled sum",
        int'(ss * 100.0), int'(es * 100.0));
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R7 out_valid in reset", out_valid, 0);
    chk(in_ready == 1'b1, "R7 in_ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // Saturated vectors: exact counts (R1, R2, R3, R4, R5)
    for (int v = 0; v < 6; v++) begin
      put(TV[v][0], TV[v][1], TV[v][2]);
      chk(out_valid == 1'b1, "R5 valid one cycle after accept", out_valid, 1);
      chk(prod_cnt == 7'(TV[v][3]), "R2 R1 product count", prod_cnt, TV[v][3]);
      chk(sum_cnt == 7'(TV[v][4]), "R3 R1 scaled-sum count", sum_cnt, TV[v][4]);
      chk(int'(result) == TV[v][5], "R4 signed result", result, TV[v][5]);
      @(negedge clk);
      chk(out_valid == 1'b0, "R5 valid drops when idle", out_valid, 0);
    end

    // Back-pressure (R6)
    out_ready = 1'b0;
    put(256, 0, 0);
    chk(in_ready == 1'b0, "R6 in_ready low while stalled", in_ready, 0);
    a_val = 9'd256; b_val = 9'd0; c_val = 9'd256; in_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk(out_valid && sum_cnt == 7'd48 && int'(result) == 144,
          "R6 stalled output holds", int'(result), 144);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && sum_cnt == 7'd64, "R6 pending beat taken at release",
        sum_cnt, 64);
    chk(int'(result) == 192, "R6 R4 released beat result", result, 192);
    @(negedge clk);
    chk(out_valid == 1'b0, "R6 no duplicate beat", out_valid, 0);

    // Statistical accuracy (R8)
    stat_run(128, 128, 64);
    stat_run(192, 64, 0);

    // Reset with a stalled result (R7)
    out_ready = 1'b0;
    put(256, 256, 256);
    chk(out_valid == 1'b1, "R7 pending before reset", out_valid, 1);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R7 reset clears pending", out_valid, 0);
    chk(in_ready == 1'b1, "R7 reset restores in_ready", in_ready, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule